// File: doc/BRIEF.md
# Mixed-Width Stack Pointer Unit

This unit turns one push or pop command into a single memory access and a new stack pointer value. The operand size (2 or 4 bytes) and the stack width (16-bit or 32-bit pointer) are chosen separately for each command, so the four combinations all work. The caller supplies the current pointer, the data to push and a flag that says whether the operand is the stack pointer itself. The unit returns the committed pointer and, for pops, the value that was read.

A command is accepted while the unit is idle. The unit then holds a memory request until the memory acknowledges it. Data moves little-endian in the low byte lanes. The new pointer and the pop value are registered at the acknowledge, and a one-cycle `done` pulse follows. With a 16-bit stack only the low half of the pointer takes part: the address has its upper half cleared, and the upper half of the pointer is carried through unchanged.

Top module: `stack_ptr_unit`

## Requirements
- R1: A push writes at the pointer minus the operand size (`memWe`=1), and that decremented value becomes the new pointer.
- R2: A pop reads at the current pointer (`memWe`=0), and the new pointer is the old one plus the operand size.
- R3: With `stkWide`=0, `memAddr[31:16]` is zero, the pointer's upper 16 bits are kept, and the low 16 bits wrap modulo 65536 in both directions.
- R4: The step is 4 when `opWide`=1 and 2 when `opWide`=0, whatever the stack width. `memWide` equals `opWide` (1 means a 4-byte access).
- R5: Pushing the stack pointer (`targetSp`=1) stores the pointer value from before the decrement.
- R6: Popping into the stack pointer makes the read value the new pointer, with no increment. A 2-byte operand replaces only the low 16 bits.
- R7: `memReq` and its address stay steady until `memAck`. `spOut` changes only in the cycle of the `done` pulse, and that pulse comes one cycle after the acknowledged request.
- R8: After reset `memReq`, `done` and `busy` are 0 and `spOut` is 0. Each `done` pulse lasts one cycle.
- R9: For a 2-byte operand, `memWdata[31:16]` is zero and `popData` is `memRdata[15:0]` zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe; taken only while `busy` is 0 |
| cmdPush | input | 1 | 1 = push, 0 = pop |
| opWide | input | 1 | 1 = 4-byte operand, 0 = 2-byte operand |
| stkWide | input | 1 | 1 = 32-bit pointer, 0 = 16-bit pointer |
| targetSp | input | 1 | The operand is the stack pointer itself |
| spIn | input | 32 | Current stack pointer |
| pushData | input | 32 | Value to push |
| memRdata | input | 32 | Read data, little-endian, valid with `memAck` |
| memAck | input | 1 | Memory completes the access this cycle |
| busy | output | 1 | A command is in progress |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memWide | output | 1 | 1 = 4-byte access, 0 = 2-byte access |
| memAddr | output | 32 | Byte address |
| memWdata | output | 32 | Write data in the low byte lanes |
| spOut | output | 32 | Committed stack pointer |
| popData | output | 32 | Value from the last pop |
| done | output | 1 | One-cycle pulse after the pointer is committed |

## Verification
The assertions assume `memAck` is raised only while `memReq` is high. They also assume `memRdata` is valid in that same cycle, and that `cmdValid` is never raised while `busy` is high. The stimulus follows these rules. It issues each command only from the idle state and acknowledges only the request in flight, after a delay of zero, one or two cycles. Every access is served from a byte-addressed bench memory, so a pop returns exactly the bytes an earlier push left there.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {ST_IDLE, ST_ACCESS} spState_t;

  typedef struct packed {
    logic capture;
    logic commit;
  } ctlStrobe_t;

  typedef struct packed {
    logic push;
    logic opWide;
    logic stkWide;
    logic targetSp;
  } spCmd_t;
endpackage

// File: rtl/sp_control.sv
module sp_control
  import sp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       memAck,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       memReq,
  output logic       done
);
  spState_t state;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && cmdValid;
    strobe.commit  = (state == ST_ACCESS) && memAck;
  end

  assign busy   = (state == ST_ACCESS);
  assign memReq = (state == ST_ACCESS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strobe.commit;
      case (state)
        ST_IDLE:   if (strobe.capture) state <= ST_ACCESS;
        ST_ACCESS: if (strobe.commit)  state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic             cmdPush,
  input  logic             opWide,
  input  logic             stkWide,
  input  logic             targetSp,
  input  logic [PTR_W-1:0] spIn,
  input  logic [PTR_W-1:0] pushData,
  input  logic [PTR_W-1:0] memRdata,
  output logic             memWe,
  output logic             memWide,
  output logic [PTR_W-1:0] memAddr,
  output logic [PTR_W-1:0] memWdata,
  output logic [PTR_W-1:0] spOut,
  output logic [PTR_W-1:0] popData
);
  localparam int HALF_W     = PTR_W / 2;
  localparam int WIDE_STEP  = PTR_W / 8;
  localparam int NARROW_STEP = HALF_W / 8;

  spCmd_t           cmdQ;
  logic [PTR_W-1:0] spQ;
  logic [PTR_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= '0;
      spQ   <= '0;
      dataQ <= '0;
    end else if (strobe.capture) begin
      cmdQ  <= '{push: cmdPush, opWide: opWide, stkWide: stkWide, targetSp: targetSp};
      spQ   <= spIn;
      dataQ <= pushData;
    end
  end

  logic [PTR_W-1:0]  step;
  logic [PTR_W-1:0]  decSp;
  logic [PTR_W-1:0]  incSp;
  logic [PTR_W-1:0]  accessPtr;
  logic [PTR_W-1:0]  pushVal;
  logic [PTR_W-1:0]  rdVal;
  logic [PTR_W-1:0]  nextSp;
  logic [HALF_W-1:0] decLow;
  logic [HALF_W-1:0] incLow;

  always_comb begin
    step   = cmdQ.opWide ? PTR_W'(WIDE_STEP) : PTR_W'(NARROW_STEP);
    decLow = spQ[HALF_W-1:0] - step[HALF_W-1:0];
    incLow = spQ[HALF_W-1:0] + step[HALF_W-1:0];
    decSp  = cmdQ.stkWide ? (spQ - step) : {spQ[PTR_W-1:HALF_W], decLow};
    incSp  = cmdQ.stkWide ? (spQ + step) : {spQ[PTR_W-1:HALF_W], incLow};

    accessPtr = cmdQ.push ? decSp : spQ;
    memAddr   = cmdQ.stkWide ? accessPtr : {{HALF_W{1'b0}}, accessPtr[HALF_W-1:0]};

    pushVal  = cmdQ.targetSp ? spQ : dataQ;
    memWdata = cmdQ.opWide ? pushVal : {{HALF_W{1'b0}}, pushVal[HALF_W-1:0]};
    memWe    = cmdQ.push;
    memWide  = cmdQ.opWide;

    rdVal = cmdQ.opWide ? memRdata : {{HALF_W{1'b0}}, memRdata[HALF_W-1:0]};

    if (cmdQ.push)
      nextSp = decSp;
    else if (cmdQ.targetSp)
      nextSp = cmdQ.opWide ? rdVal : {spQ[PTR_W-1:HALF_W], rdVal[HALF_W-1:0]};
    else
      nextSp = incSp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spOut   <= '0;
      popData <= '0;
    end else if (strobe.commit) begin
      spOut <= nextSp;
      if (!cmdQ.push) popData <= rdVal;
    end
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdPush,
  input  logic             opWide,
  input  logic             stkWide,
  input  logic             targetSp,
  input  logic [PTR_W-1:0] spIn,
  input  logic [PTR_W-1:0] pushData,
  input  logic [PTR_W-1:0] memRdata,
  input  logic             memAck,
  output logic             busy,
  output logic             memReq,
  output logic             memWe,
  output logic             memWide,
  output logic [PTR_W-1:0] memAddr,
  output logic [PTR_W-1:0] memWdata,
  output logic [PTR_W-1:0] spOut,
  output logic [PTR_W-1:0] popData,
  output logic             done
);
  ctlStrobe_t strobe;

  sp_control u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .memAck(memAck),
    .strobe(strobe), .busy(busy), .memReq(memReq), .done(done)
  );

  sp_datapath #(.PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdPush(cmdPush), .opWide(opWide), .stkWide(stkWide), .targetSp(targetSp),
    .spIn(spIn), .pushData(pushData), .memRdata(memRdata),
    .memWe(memWe), .memWide(memWide), .memAddr(memAddr), .memWdata(memWdata),
    .spOut(spOut), .popData(popData)
  );
endmodule

// File: rtl/sp_unit_checker.sv
module sp_unit_checker #(
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             memReq,
  input logic             memAck,
  input logic             memWe,
  input logic             memWide,
  input logic [PTR_W-1:0] memAddr,
  input logic [PTR_W-1:0] memWdata,
  input logic [PTR_W-1:0] spOut,
  input logic             done
);
  localparam int HALF_W = PTR_W / 2;

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  assert_done_after_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memReq && memAck));

  assert_sp_moves_on_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(spOut));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_narrow_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !memWide) |-> (memWdata[PTR_W-1:HALF_W] == '0));
endmodule

bind stack_ptr_unit sp_unit_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck), .memWe(memWe),
  .memWide(memWide), .memAddr(memAddr), .memWdata(memWdata), .spOut(spOut),
  .done(done)
);

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdPush = 1'b0, opWide = 1'b0, stkWide = 1'b0, targetSp = 1'b0;
  logic [31:0] spIn = '0, pushData = '0, memRdata = '0;
  logic        memAck = 1'b0;
  logic        busy, memReq, memWe, memWide, done;
  logic [31:0] memAddr, memWdata, spOut, popData;

  int checkCount = 0;
  int failCount = 0;
  int cyc = 0;
  logic [31:0] lastSp = '0;
  logic [7:0] mem [int];

  always #10 clk = ~clk;

  stack_ptr_unit dut (.*);

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      failCount++;
      $display("FAIL R7 watchdog: actual hung, expected completion");
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rdMem(int addr, int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++)
      if (mem.exists(addr + i)) v[8*i +: 8] = mem[addr + i];
    return v;
  endfunction

  task automatic runOp(bit push, bit ow, bit sw, bit tgt, logic [31:0] sp,
                       logic [31:0] data, int ackDelay);
    int step = ow ? 4 : 2;
    int nBytes = ow ? 4 : 2;
    logic [31:0] expSp, expAddr, expW, val;
    logic [15:0] lo;
    @(negedge clk);
    cmdValid = 1; cmdPush = push; opWide = ow; stkWide = sw; targetSp = tgt;
    spIn = sp; pushData = data;
    if (push) begin
      lo = sp[15:0] - 16'(step);
      expSp = sw ? sp - 32'(step) : {sp[31:16], lo};
      expAddr = sw ? expSp : {16'h0, expSp[15:0]};
      expW = tgt ? sp : data;
      if (!ow) expW = {16'h0, expW[15:0]};
    end else begin
      expAddr = sw ? sp : {16'h0, sp[15:0]};
      expW = 'x;
      expSp = 'x;
    end
    @(negedge clk);
    cmdValid = 0;
    for (int w = 0; w <= ackDelay; w++) begin
      chk("R7 memReq held", {31'b0, memReq}, 32'd1);
      chk(push ? "R1/R3 push addr" : "R2/R3 pop addr", memAddr, expAddr);
      chk("R1/R2 write enable", {31'b0, memWe}, {31'b0, push});
      chk("R4 access size", {31'b0, memWide}, {31'b0, ow});
      if (push) chk("R5/R9 write data", memWdata, expW);
      chk("R7 spOut steady", spOut, lastSp);
      chk("R7 no early done", {31'b0, done}, 32'd0);
      if (w == ackDelay) begin
        memAck = 1;
        if (push) begin
          for (int i = 0; i < nBytes; i++) mem[int'(expAddr) + i] = expW[8*i +: 8];
          memRdata = 32'hFFFF_FFFF;
        end else begin
          memRdata = rdMem(int'(expAddr), 4);
          val = ow ? memRdata : {16'h0, memRdata[15:0]};
          if (tgt) expSp = ow ? val : {sp[31:16], val[15:0]};
          else begin
            lo = sp[15:0] + 16'(step);
            expSp = sw ? sp + 32'(step) : {sp[31:16], lo};
          end
        end
      end
      @(negedge clk);
    end
    memAck = 0;
    chk("R7 done pulse", {31'b0, done}, 32'd1);
    chk(push ? "R1/R3/R5 new pointer" : (tgt ? "R6 popped pointer" : "R2/R3 new pointer"),
        spOut, expSp);
    if (!push) chk("R9 pop data", popData, val);
    chk("R7 request dropped", {31'b0, memReq}, 32'd0);
    lastSp = expSp;
    @(negedge clk);
    chk("R8 done single", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset memReq", {31'b0, memReq}, 32'd0);
    chk("R8 reset done", {31'b0, done}, 32'd0);
    chk("R8 reset busy", {31'b0, busy}, 32'd0);
    chk("R8 reset spOut", spOut, 32'd0);
    rstN = 1;
    // R1 wide push on wide stack
    runOp(1, 1, 1, 0, 32'h0000_1000, 32'hA1B2_C3D4, 0);
    // R2 wide pop returns little-endian bytes
    runOp(0, 1, 1, 0, 32'h0000_0FFC, 32'h0, 1);
    // R4 R9 narrow operand on wide stack
    runOp(1, 0, 1, 0, 32'h0000_2000, 32'hDEAD_5678, 0);
    // R3 R4 wide operand on narrow stack, low half wraps down
    runOp(1, 1, 0, 0, 32'hABCD_0002, 32'h1122_3344, 1);
    // R3 narrow pop wraps up, upper half kept
    runOp(0, 0, 0, 0, 32'h5555_FFFE, 32'h0, 2);
    // R5 push pointer itself
    runOp(1, 1, 1, 1, 32'h0000_3000, 32'h0, 0);
    runOp(1, 0, 0, 1, 32'h1234_0100, 32'h0, 1);
    // R6 pop into pointer
    runOp(0, 1, 1, 1, 32'h0000_2FFC, 32'h0, 0);
    runOp(0, 0, 0, 1, 32'hCAFE_00FE, 32'h0, 2);
    runOp(0, 0, 1, 1, 32'h0000_1FFE, 32'h0, 1);
    summary();
    $finish;
  end
endmodule